// File: doc/BRIEF.md
# Memory Device Power State Controller

This block keeps track of which power state one memory device is in and decides when the device may accept column packets. It changes state on decoded row commands (powerdown, nap, relax) addressed to the device and on column read and write commands. It also leaves the two low-power states when a wake-up frame arrives on a slow serial command wire. That wire is sampled on the rising edges of its own serial clock, which are detected in the core clock domain.

Leaving a low-power state takes a programmed number of serial clock edges, counted in whole units of `UNIT` edges. Leaving powerdown runs two phases back to back, each with its own length field. Leaving nap uses a single length field. A configuration input decides whether every device accepts any wake-up frame, or only the device whose identifier matches the address carried in the frame. The block reports its state code and a column-enable flag.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset the state is powerdown (code 0) and `col_en` is low.
- R2: State codes are powerdown 0, nap 1, standby 2, active 3, active-read 4 and active-write 5. `col_en` is high exactly in codes 3, 4 and 5.
- R3: In codes 3, 4 and 5, a column command moves the state to 4 on the next cycle when `col_rd` is 1, and to 5 when `col_rd` is 0. A cycle with no column command returns code 4 or 5 to 3. Column commands have no effect in codes 0, 1 and 2.
- R4: The row op encoding is 1 powerdown, 2 nap and 3 relax, and 0 means no power command. A row op acts only when `row_vld` and `row_hit` are both high. Powerdown and nap are taken only from active (3) or standby (2). In active they win over a column command in the same cycle. Row ops are ignored in all other states.
- R5: Relax moves active (3) to standby (2). In every other state it has no effect.
- R6: In powerdown or nap, with no exit in progress, a wake-up frame is read on rising serial clock edges. The frame is a start bit of 1, then `DEV_W` address bits with the most significant bit first, then one target bit.
- R7: With `cfg_exit_bcast` = 1 every frame starts an exit. With it at 0, only a frame whose address equals `dev_id` starts an exit. A frame that does not start an exit leaves the state unchanged.
- R8: An exit from powerdown completes after (`cfg_pd_exit_a` + `cfg_pd_exit_b`)·`UNIT` rising serial clock edges that follow the frame. Phase A runs before phase B. An exit from nap completes after `cfg_nap_exit`·`UNIT` edges. A field of zero adds no edges. The state holds until the exit completes.
- R9: When an exit completes, the state becomes active (3) if the target bit was 1 and standby (2) if it was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_vld | input | 1 | Decoded row command valid |
| row_op | input | 2 | Row power op: 0 none, 1 powerdown, 2 nap, 3 relax |
| row_hit | input | 1 | Row command is addressed to this device |
| col_vld | input | 1 | Column read/write command valid |
| col_rd | input | 1 | 1 read, 0 write |
| ser_clk | input | 1 | Serial wake-up clock, sampled |
| ser_cmd | input | 1 | Serial wake-up data wire |
| cfg_exit_bcast | input | 1 | 1: any frame wakes; 0: address must match |
| dev_id | input | DEV_W | This device's identifier |
| cfg_pd_exit_a | input | PDA_W | Powerdown exit phase A length in units |
| cfg_pd_exit_b | input | PDB_W | Powerdown exit phase B length in units |
| cfg_nap_exit | input | NAP_W | Nap exit length in units |
| pwr_state | output | 3 | Current state code |
| col_en | output | 1 | Column packets may be accepted |

## Verification
The bench steps the controller through every state edge with single-cycle command pulses. These include a row op paired with a column command in the same cycle, which shows whether row ops take priority in active and are ignored in active-read. Exits are swept over nap and powerdown with phase lengths of zero, one and two units, placed in phase A only, phase B only and both phases. Each exit is sampled one serial edge before the expected end and again just after it, so an error of one unit or a swapped phase shows up. Frames with matching and non-matching addresses under both exit modes separate broadcast from directed wake-up, and the target bit is checked in both polarities.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    PS_PWRDN   = 3'd0,
    PS_NAP     = 3'd1,
    PS_STANDBY = 3'd2,
    PS_ACTIVE  = 3'd3,
    PS_ACT_RD  = 3'd4,
    PS_ACT_WR  = 3'd5
  } pwr_state_e;

  typedef enum logic [1:0] {
    ROP_NONE  = 2'd0,
    ROP_PWRDN = 2'd1,
    ROP_NAP   = 2'd2,
    ROP_RELAX = 2'd3
  } row_op_e;

  typedef enum logic [1:0] {
    TP_IDLE = 2'd0,
    TP_A    = 2'd1,
    TP_B    = 2'd2
  } tmr_phase_e;
endpackage

// File: rtl/pwr_wake_rx.sv
module pwr_wake_rx #(
  parameter int DEV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             bit_stb,
  input  logic             bit_val,
  output logic             frame_vld,
  output logic [DEV_W-1:0] frame_addr,
  output logic             frame_tgt
);
  localparam int FRAME_W = DEV_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic               busy_q, busy_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [FRAME_W-1:0] frm_q, frm_d;
  logic               vld_q, vld_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    frm_d  = frm_q;
    vld_d  = 1'b0;
    if (!en) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (bit_stb) begin
      if (!busy_q) begin
        if (bit_val) begin
          busy_d = 1'b1;
          cnt_d  = '0;
        end
      end else begin
        sh_d = {sh_q[FRAME_W-2:0], bit_val};
        if (cnt_q == LAST) begin
          busy_d = 1'b0;
          cnt_d  = '0;
          vld_d  = 1'b1;
          frm_d  = {sh_q[FRAME_W-2:0], bit_val};
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      frm_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      frm_q  <= frm_d;
      vld_q  <= vld_d;
    end
  end

  assign frame_vld  = vld_q;
  assign frame_addr = frm_q[FRAME_W-1:1];
  assign frame_tgt  = frm_q[0];
endmodule

// File: rtl/pwr_exit_timer.sv
module pwr_exit_timer
  import pwr_pkg::*;
#(
  parameter int A_W  = 5,
  parameter int B_W  = 5,
  parameter int N_W  = 5,
  parameter int UNIT = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           start_pd,
  input  logic           tick,
  input  logic [A_W-1:0] len_a,
  input  logic [B_W-1:0] len_b,
  input  logic [N_W-1:0] len_nap,
  output logic           busy,
  output logic           done
);
  localparam int AB_W   = (A_W > B_W) ? A_W : B_W;
  localparam int REM_W  = (AB_W > N_W) ? AB_W : N_W;
  localparam int UNIT_W = (UNIT > 1) ? $clog2(UNIT) : 1;
  localparam logic [UNIT_W-1:0] U_LAST = UNIT_W'(UNIT - 1);

  tmr_phase_e         ph_q, ph_d;
  logic [REM_W-1:0]   rem_q, rem_d;
  logic [UNIT_W-1:0]  unit_q, unit_d;
  logic               done_q, done_d;

  always_comb begin
    ph_d   = ph_q;
    rem_d  = rem_q;
    unit_d = unit_q;
    done_d = 1'b0;
    case (ph_q)
      TP_IDLE: begin
        if (start) begin
          unit_d = '0;
          if (start_pd) begin
            ph_d  = TP_A;
            rem_d = REM_W'(len_a);
          end else begin
            ph_d  = TP_B;
            rem_d = REM_W'(len_nap);
          end
        end
      end
      TP_A, TP_B: begin
        if (rem_q == '0) begin
          unit_d = '0;
          if (ph_q == TP_A) begin
            ph_d  = TP_B;
            rem_d = REM_W'(len_b);
          end else begin
            ph_d   = TP_IDLE;
            done_d = 1'b1;
          end
        end else if (tick) begin
          if (unit_q == U_LAST) begin
            unit_d = '0;
            rem_d  = rem_q - 1'b1;
          end else begin
            unit_d = unit_q + 1'b1;
          end
        end
      end
      default: ph_d = TP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= TP_IDLE;
      rem_q  <= '0;
      unit_q <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      rem_q  <= rem_d;
      unit_q <= unit_d;
      done_q <= done_d;
    end
  end

  assign busy = (ph_q != TP_IDLE);
  assign done = done_q;
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_pkg::*;
#(
  parameter int DEV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_vld,
  input  logic [1:0]       row_op,
  input  logic             row_hit,
  input  logic             col_vld,
  input  logic             col_rd,
  input  logic             frame_vld,
  input  logic [DEV_W-1:0] frame_addr,
  input  logic             frame_tgt,
  input  logic             cfg_bcast,
  input  logic [DEV_W-1:0] dev_id,
  input  logic             tmr_busy,
  input  logic             tmr_done,
  output pwr_state_e       state,
  output logic             exit_start,
  output logic             exit_pd,
  output logic             rx_en
);
  pwr_state_e st_q, st_d;
  logic       tgt_q, tgt_d;
  logic       low_pwr;
  logic       row_go;
  logic       addr_ok;

  assign low_pwr    = (st_q == PS_PWRDN) || (st_q == PS_NAP);
  assign row_go     = row_vld && row_hit;
  assign addr_ok    = cfg_bcast || (frame_addr == dev_id);
  assign exit_start = frame_vld && low_pwr && !tmr_busy && addr_ok;
  assign exit_pd    = (st_q == PS_PWRDN);
  assign rx_en      = low_pwr && !tmr_busy;

  always_comb begin
    st_d  = st_q;
    tgt_d = exit_start ? frame_tgt : tgt_q;
    case (st_q)
      PS_PWRDN, PS_NAP: begin
        if (tmr_done) st_d = tgt_q ? PS_ACTIVE : PS_STANDBY;
      end
      PS_STANDBY: begin
        if (row_go && row_op == ROP_PWRDN)     st_d = PS_PWRDN;
        else if (row_go && row_op == ROP_NAP)  st_d = PS_NAP;
      end
      PS_ACTIVE: begin
        if (row_go && row_op == ROP_PWRDN)      st_d = PS_PWRDN;
        else if (row_go && row_op == ROP_NAP)   st_d = PS_NAP;
        else if (row_go && row_op == ROP_RELAX) st_d = PS_STANDBY;
        else if (col_vld)                       st_d = col_rd ? PS_ACT_RD : PS_ACT_WR;
      end
      PS_ACT_RD, PS_ACT_WR: begin
        if (col_vld) st_d = col_rd ? PS_ACT_RD : PS_ACT_WR;
        else         st_d = PS_ACTIVE;
      end
      default: st_d = PS_PWRDN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_PWRDN;
      tgt_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      tgt_q <= tgt_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_pkg::*;
#(
  parameter int DEV_W  = 5,
  parameter int PDA_W  = 5,
  parameter int PDB_W  = 5,
  parameter int NAP_W  = 5,
  parameter int UNIT   = 64,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_vld,
  input  logic [1:0]       row_op,
  input  logic             row_hit,
  input  logic             col_vld,
  input  logic             col_rd,
  input  logic             ser_clk,
  input  logic             ser_cmd,
  input  logic             cfg_exit_bcast,
  input  logic [DEV_W-1:0] dev_id,
  input  logic [PDA_W-1:0] cfg_pd_exit_a,
  input  logic [PDB_W-1:0] cfg_pd_exit_b,
  input  logic [NAP_W-1:0] cfg_nap_exit,
  output logic [2:0]       pwr_state,
  output logic             col_en
);
  logic [SYNC_N-1:0] sck_pipe;
  logic [SYNC_N-1:0] cmd_pipe;
  logic              sck_last;
  logic              sck_rise;

  genvar g;
  generate
    for (g = 0; g < SYNC_N; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_pipe[g] <= 1'b0;
          cmd_pipe[g] <= 1'b0;
        end else begin
          sck_pipe[g] <= (g == 0) ? ser_clk : sck_pipe[(g == 0) ? 0 : g-1];
          cmd_pipe[g] <= (g == 0) ? ser_cmd : cmd_pipe[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_last <= 1'b0;
    else        sck_last <= sck_pipe[SYNC_N-1];
  end

  assign sck_rise = sck_pipe[SYNC_N-1] && !sck_last;

  logic             rx_en;
  logic             frame_vld;
  logic [DEV_W-1:0] frame_addr;
  logic             frame_tgt;
  logic             exit_start;
  logic             exit_pd;
  logic             tmr_busy;
  logic             exit_done;
  pwr_state_e       state;

  pwr_wake_rx #(.DEV_W(DEV_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (rx_en),
    .bit_stb    (sck_rise),
    .bit_val    (cmd_pipe[SYNC_N-1]),
    .frame_vld  (frame_vld),
    .frame_addr (frame_addr),
    .frame_tgt  (frame_tgt)
  );

  pwr_exit_timer #(.A_W(PDA_W), .B_W(PDB_W), .N_W(NAP_W), .UNIT(UNIT)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (exit_start),
    .start_pd (exit_pd),
    .tick     (sck_rise),
    .len_a    (cfg_pd_exit_a),
    .len_b    (cfg_pd_exit_b),
    .len_nap  (cfg_nap_exit),
    .busy     (tmr_busy),
    .done     (exit_done)
  );

  pwr_state_fsm #(.DEV_W(DEV_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .row_vld    (row_vld),
    .row_op     (row_op),
    .row_hit    (row_hit),
    .col_vld    (col_vld),
    .col_rd     (col_rd),
    .frame_vld  (frame_vld),
    .frame_addr (frame_addr),
    .frame_tgt  (frame_tgt),
    .cfg_bcast  (cfg_exit_bcast),
    .dev_id     (dev_id),
    .tmr_busy   (tmr_busy),
    .tmr_done   (exit_done),
    .state      (state),
    .exit_start (exit_start),
    .exit_pd    (exit_pd),
    .rx_en      (rx_en)
  );

  assign pwr_state = state;
  assign col_en    = (state == PS_ACTIVE) || (state == PS_ACT_RD) || (state == PS_ACT_WR);
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk
  import pwr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] pwr_state,
  input logic       col_en,
  input logic       row_vld,
  input logic [1:0] row_op,
  input logic       row_hit,
  input logic       col_vld,
  input logic       col_rd,
  input logic       exit_done
);
  logic low_pwr, act_sub, row_pwr, row_relax;
  assign low_pwr   = (pwr_state == PS_PWRDN) || (pwr_state == PS_NAP);
  assign act_sub   = (pwr_state == PS_ACT_RD) || (pwr_state == PS_ACT_WR);
  assign row_pwr   = row_vld && row_hit && (row_op == ROP_PWRDN || row_op == ROP_NAP);
  assign row_relax = row_vld && row_hit && (row_op == ROP_RELAX);

  p_colen_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_en) |-> ($past(pwr_state) == PS_PWRDN || $past(pwr_state) == PS_NAP));

  p_rd_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_sub || (pwr_state == PS_ACTIVE && !row_pwr && !row_relax)) && col_vld && col_rd)
    |=> pwr_state == PS_ACT_RD);

  p_wr_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_sub || (pwr_state == PS_ACTIVE && !row_pwr && !row_relax)) && col_vld && !col_rd)
    |=> pwr_state == PS_ACT_WR);

  p_idle_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_sub && !col_vld) |=> pwr_state == PS_ACTIVE);

  p_standby_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PS_STANDBY && !row_pwr) |=> pwr_state == PS_STANDBY);

  p_relax_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PS_ACTIVE && row_relax) |=> pwr_state == PS_STANDBY);

  p_lowpwr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (low_pwr && !exit_done) |=> pwr_state == $past(pwr_state));

  p_exit_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (low_pwr && exit_done) |=> (pwr_state == PS_ACTIVE || pwr_state == PS_STANDBY));
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_state (pwr_state),
  .col_en    (col_en),
  .row_vld   (row_vld),
  .row_op    (row_op),
  .row_hit   (row_hit),
  .col_vld   (col_vld),
  .col_rd    (col_rd),
  .exit_done (exit_done)
);

// File: tb/tb_pwr_state_ctrl.sv
module tb_pwr_state_ctrl;
  localparam int DEV_W = 5;
  localparam int UNIT  = 64;
  localparam int S_PD = 0, S_NAP = 1, S_SB = 2, S_AC = 3, S_RD = 4, S_WR = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic row_vld, row_hit, col_vld, col_rd, ser_clk, ser_cmd, cfg_exit_bcast;
  logic [1:0] row_op;
  logic [DEV_W-1:0] dev_id;
  logic [4:0] cfg_pd_exit_a, cfg_pd_exit_b, cfg_nap_exit;
  logic [2:0] pwr_state;
  logic col_en;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pwr_state_ctrl dut (
    .clk(clk), .rst_n(rst_n), .row_vld(row_vld), .row_op(row_op), .row_hit(row_hit),
    .col_vld(col_vld), .col_rd(col_rd), .ser_clk(ser_clk), .ser_cmd(ser_cmd),
    .cfg_exit_bcast(cfg_exit_bcast), .dev_id(dev_id), .cfg_pd_exit_a(cfg_pd_exit_a),
    .cfg_pd_exit_b(cfg_pd_exit_b), .cfg_nap_exit(cfg_nap_exit),
    .pwr_state(pwr_state), .col_en(col_en)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input int exp, input string req);
    logic exp_en;
    exp_en = (exp >= S_AC);
    n_chk++;
    if (pwr_state !== 3'(exp) || col_en !== exp_en) begin
      n_bad++;
      $display("FAIL %s: state=%0d col_en=%0b expected state=%0d col_en=%0b",
               req, pwr_state, col_en, exp, exp_en);
    end
  endtask

  task automatic cmd(input logic rv, input logic [1:0] op, input logic hit,
                     input logic cv, input logic rd);
    row_vld = rv; row_op = op; row_hit = hit; col_vld = cv; col_rd = rd;
    tick(1);
    row_vld = 1'b0; row_op = 2'd0; row_hit = 1'b0; col_vld = 1'b0; col_rd = 1'b0;
  endtask

  task automatic sck_cycle(input logic b);
    ser_cmd = b;
    tick(4);
    ser_clk = 1'b1;
    tick(4);
    ser_clk = 1'b0;
  endtask

  task automatic send_frame(input logic [DEV_W-1:0] addr, input logic tgt);
    sck_cycle(1'b1);
    for (int i = DEV_W - 1; i >= 0; i--) sck_cycle(addr[i]);
    sck_cycle(tgt);
    ser_cmd = 1'b0;
  endtask

  task automatic wake(input int units, input logic [DEV_W-1:0] addr, input logic tgt,
                      input int st_low, input int st_end, input string req);
    send_frame(addr, tgt);
    if (units > 0) begin
      repeat (units * UNIT - 1) sck_cycle(1'b0);
      check(st_low, req);
      sck_cycle(1'b0);
      tick(4);
    end else begin
      tick(16);
    end
    check(st_end, req);
  endtask

  initial begin
    rst_n = 1'b0;
    row_vld = 1'b0; row_op = 2'd0; row_hit = 1'b0; col_vld = 1'b0; col_rd = 1'b0;
    ser_clk = 1'b0; ser_cmd = 1'b0; cfg_exit_bcast = 1'b0; dev_id = 5'h0B;
    cfg_pd_exit_a = 5'd1; cfg_pd_exit_b = 5'd1; cfg_nap_exit = 5'd2;
    tick(3);
    check(S_PD, "R1 reset");
    rst_n = 1'b1;
    tick(2);
    check(S_PD, "R1 after release");

    cmd(1'b0, 2'd0, 1'b0, 1'b1, 1'b1);
    check(S_PD, "R3 column ignored in powerdown");
    cmd(1'b1, 2'd2, 1'b1, 1'b0, 1'b0);
    check(S_PD, "R4 nap ignored in powerdown");
    cmd(1'b1, 2'd3, 1'b1, 1'b0, 1'b0);
    check(S_PD, "R5 relax ignored in powerdown");

    // R6 R7 R8 R9: directed match, two phases of one unit each, target active
    wake(2, 5'h0B, 1'b1, S_PD, S_AC, "R8 powerdown exit a=1 b=1");

    cmd(1'b0, 2'd0, 1'b0, 1'b1, 1'b1);
    check(S_RD, "R3 read from active");
    cmd(1'b0, 2'd0, 1'b0, 1'b1, 1'b1);
    check(S_RD, "R3 read held");
    cmd(1'b0, 2'd0, 1'b0, 1'b1, 1'b0);
    check(S_WR, "R3 write from read");
    tick(1);
    check(S_AC, "R3 idle returns to active");
    cmd(1'b0, 2'd0, 1'b0, 1'b1, 1'b1);
    cmd(1'b1, 2'd1, 1'b1, 1'b1, 1'b1);
    check(S_RD, "R4 powerdown ignored in active-read");
    tick(1);
    check(S_AC, "R3 return to active");
    cmd(1'b1, 2'd3, 1'b0, 1'b0, 1'b0);
    check(S_AC, "R4 row op without hit ignored");
    cmd(1'b1, 2'd3, 1'b1, 1'b0, 1'b0);
    check(S_SB, "R5 relax active to standby");
    cmd(1'b0, 2'd0, 1'b0, 1'b1, 1'b1);
    check(S_SB, "R3 column ignored in standby");
    cmd(1'b1, 2'd3, 1'b1, 1'b0, 1'b0);
    check(S_SB, "R5 relax ignored in standby");
    cmd(1'b1, 2'd2, 1'b1, 1'b0, 1'b0);
    check(S_NAP, "R4 nap from standby");

    // R7: directed mode, wrong address, no exit
    send_frame(5'h04, 1'b1);
    repeat (3 * UNIT) sck_cycle(1'b0);
    check(S_NAP, "R7 mismatch ignored");

    cfg_exit_bcast = 1'b1;
    wake(2, 5'h04, 1'b0, S_NAP, S_SB, "R7 broadcast nap exit to standby R9");

    cmd(1'b1, 2'd1, 1'b1, 1'b0, 1'b0);
    check(S_PD, "R4 powerdown from standby");
    cfg_exit_bcast = 1'b0; cfg_pd_exit_a = 5'd0; cfg_pd_exit_b = 5'd0;
    wake(0, 5'h0B, 1'b1, S_PD, S_AC, "R8 zero-length powerdown exit");

    cmd(1'b1, 2'd2, 1'b1, 1'b1, 1'b1);
    check(S_NAP, "R4 nap wins over column in active");
    cfg_nap_exit = 5'd0;
    wake(0, 5'h0B, 1'b1, S_NAP, S_AC, "R8 zero-length nap exit");

    cmd(1'b1, 2'd1, 1'b1, 1'b0, 1'b0);
    check(S_PD, "R4 powerdown from active");
    cfg_pd_exit_a = 5'd0; cfg_pd_exit_b = 5'd1;
    wake(1, 5'h0B, 1'b0, S_PD, S_SB, "R8 phase B only");

    cmd(1'b1, 2'd1, 1'b1, 1'b0, 1'b0);
    check(S_PD, "R4 powerdown from standby again");
    cfg_pd_exit_a = 5'd2; cfg_pd_exit_b = 5'd0;
    wake(2, 5'h0B, 1'b1, S_PD, S_AC, "R8 phase A only R9");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run incomplete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule